// File: doc/BRIEF.md
# Multiplexed-Bus External Memory Master

This block fetches and stores single bytes in an external byte-wide memory that is reached through an 8-bit bus shared by address and data. Two external address latches, chained so that each capture moves the older byte into the upper latch, sit on the bus. The block writes the two low address bytes into them one after the other, then either releases the bus and reads the addressed byte, or drives a byte and pulses a write enable. A typical user is a boot loader that pulls firmware out of a parallel ROM one byte at a time.

The internal side is a simple request port. When `req_ready` is high, a cycle with `req_valid` high starts a read or a write to `req_addr`. Completion is a one-cycle `done` pulse, carrying the read byte on `rdata`. Only bits 15:0 of the 24-bit address leave the block; any wider memory is paged by the host on its own pins. The bus is modelled as separate drive value, drive enable and sampled input. Every phase is `PHASE_CYC` clock cycles long (P below, default 2, at least 2), so slow memories can be met.

Top module: `xmem_mux_master`

## Requirements
- R1: During reset and whenever the block is idle, `strb_n` and `wen_n` are high, `bus_oe` is low, `done` is low and `req_ready` is high.
- R2: A transaction starts with two address phases of P cycles each: `bus_out` carries address bits 15:8 and then bits 7:0 with `bus_oe` high. In each phase `strb_n` is low for the first P-1 cycles and high in the last, with the byte held. The rising edge of `strb_n` shifts the lower latch into the upper one and loads the bus into the lower one, so the latches then hold address bits 15:0.
- R3: Address bits 23:16 never reach the bus. Two addresses that differ only in those bits reach the same memory byte.
- R4: In a read, the second address phase is followed by exactly one cycle with the bus released and both strobes high.
- R5: A read then holds `strb_n` low for P cycles with the bus released. `bus_in` is sampled on the clock edge that ends the last of these cycles, and `rdata` shows that byte in the cycle after, with `done` high. Counting the accepting edge as edge 0, `done` is high in cycle 3P+2 after it.
- R6: A write follows the address phases with P cycles in which `bus_out` carries the write byte and `strb_n` stays high. `wen_n` is low for the first P-1 of these cycles and high in the last, with the byte held. `done` is high in the cycle after.
- R7: `strb_n` and `wen_n` are never low together, and the bus is never driven while the read data phase has `strb_n` low.
- R8: A request is taken only when `req_ready` is high. A `req_valid` raised during a transaction has no effect: the running transaction is unchanged, no further transaction follows, and the memory is not written.
- R9: `done` lasts exactly one cycle per accepted request. `req_ready` is already high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address; bits 23:16 are not emitted |
| req_wdata | input | 8 | Byte to store on a write |
| req_ready | output | 1 | Block idle, may take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte read, valid with done after a read |
| bus_out | output | 8 | Value driven onto the shared bus |
| bus_oe | output | 1 | Bus drive enable; low means high impedance |
| bus_in | input | 8 | Value sampled from the shared bus |
| strb_n | output | 1 | Active-low strobe: address latch enable and memory output enable |
| wen_n | output | 1 | Active-low memory write enable |

## Verification
The bench runs a behavioural model of the chained latches and memory, and compares every pin in every cycle of every transaction against a table built from the phase rules. A design that strobed with the byte still changing, or that put the low byte out first, would leave the wrong address in the latches and read or write the wrong byte. A design that skipped the turnaround cycle, or drove the bus during the data phase, fails the per-cycle pin comparison. Reads at addresses that differ only in the top byte catch a design that leaks or uses bits 23:16. A request raised mid-read with the write flag set catches a design that restarts, queues the request or writes memory while busy. A `done` that is stretched, doubled or placed one cycle off shows up against the fixed latency.

// File: rtl/mmx_pkg.sv
package mmx_pkg;

  typedef enum logic [2:0] {
    MX_IDLE,
    MX_AHI,
    MX_ALO,
    MX_TURN,
    MX_RDAT,
    MX_WDAT
  } mx_state_e;

  // Bus is driven during both address phases and the write data phase.
  function automatic logic mx_drives(input mx_state_e s);
    return (s == MX_AHI) || (s == MX_ALO) || (s == MX_WDAT);
  endfunction

  // Combined strobe: low in address phases except their hold cycle,
  // low for the whole read data phase.
  function automatic logic mx_strb_low(input mx_state_e s, input logic last);
    return (s == MX_RDAT) || (((s == MX_AHI) || (s == MX_ALO)) && !last);
  endfunction

  function automatic logic mx_wen_low(input mx_state_e s, input logic last);
    return (s == MX_WDAT) && !last;
  endfunction

endpackage

// File: rtl/mmx_seq.sv
module mmx_seq
  import mmx_pkg::*;
#(
  parameter int PHASE_CYC = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      is_wr,
  output mx_state_e st,
  output logic      last,
  output logic      accept,
  output logic      rd_end,
  output logic      wr_end,
  output logic      ready
);
  localparam int CW = $clog2(PHASE_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CYC - 1);

  logic [CW-1:0] cnt;

  assign ready  = (st == MX_IDLE);
  assign accept = ready && req_valid;
  assign last   = (st == MX_TURN) || (cnt == CNT_LAST);
  assign rd_end = (st == MX_RDAT) && last;
  assign wr_end = (st == MX_WDAT) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= MX_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        MX_IDLE: begin
          cnt <= '0;
          if (req_valid) st <= MX_AHI;
        end
        MX_TURN: begin
          cnt <= '0;
          st  <= MX_RDAT;
        end
        default: begin
          if (last) begin
            cnt <= '0;
            case (st)
              MX_AHI:  st <= MX_ALO;
              MX_ALO:  st <= is_wr ? MX_WDAT : MX_TURN;
              default: st <= MX_IDLE;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R2: the low address phase is only ever entered from the high one
  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MX_ALO && $past(st) != MX_ALO) |-> $past(st) == MX_AHI);

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_LAST);

endmodule

// File: rtl/mmx_hold.sv
module mmx_hold #(
  parameter int LAT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [LAT_W-1:0]  req_addr_lo,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              h_wr,
  output logic [LAT_W-1:0]  h_addr,
  output logic [DATA_W-1:0] h_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_wr    <= 1'b0;
      h_addr  <= '0;
      h_wdata <= '0;
    end else if (accept) begin
      h_wr    <= req_write;
      h_addr  <= req_addr_lo;
      h_wdata <= req_wdata;
    end
  end
endmodule

// File: rtl/mmx_pins.sv
module mmx_pins
  import mmx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LAT_W  = 16
) (
  input  mx_state_e         st,
  input  logic              last,
  input  logic [LAT_W-1:0]  h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              strb_n,
  output logic              wen_n
);
  // Byte k of the latched address range, k = 0 is the least significant.
  function automatic logic [DATA_W-1:0] lat_byte(input logic [LAT_W-1:0] a, input int k);
    return a[k*DATA_W +: DATA_W];
  endfunction

  always_comb begin
    case (st)
      MX_AHI:  bus_out = lat_byte(h_addr, 1);
      MX_ALO:  bus_out = lat_byte(h_addr, 0);
      MX_WDAT: bus_out = h_wdata;
      default: bus_out = '0;
    endcase
  end

  assign bus_oe = mx_drives(st);
  assign strb_n = !mx_strb_low(st, last);
  assign wen_n  = !mx_wen_low(st, last);
endmodule

// File: rtl/mmx_capture.sv
module mmx_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_end,
  input  logic              wr_end,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= rd_end || wr_end;
      if (rd_end) rdata <= bus_in;
    end
  end

  // R9: completion never lasts beyond one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/xmem_mux_master.sv
module xmem_mux_master
  import mmx_pkg::*;
#(
  parameter int PHASE_CYC = 2,
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_in,
  output logic              strb_n,
  output logic              wen_n
);
  localparam int LAT_BYTES = 2;
  localparam int LAT_W     = LAT_BYTES * DATA_W;

  mx_state_e         st;
  logic              last, accept, rd_end, wr_end;
  logic              h_wr;
  logic [LAT_W-1:0]  h_addr;
  logic [DATA_W-1:0] h_wdata;
  logic              rd_phase;

  // Upper address bits are dropped; paging them is the host's job.
  logic unused_top;
  assign unused_top = ^req_addr[ADDR_W-1:LAT_W];

  mmx_seq #(.PHASE_CYC(PHASE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_wr(h_wr),
    .st(st), .last(last), .accept(accept), .rd_end(rd_end),
    .wr_end(wr_end), .ready(req_ready)
  );

  mmx_hold #(.LAT_W(LAT_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_write(req_write),
    .req_addr_lo(req_addr[LAT_W-1:0]), .req_wdata(req_wdata),
    .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata)
  );

  mmx_pins #(.DATA_W(DATA_W), .LAT_W(LAT_W)) u_pins (
    .st(st), .last(last), .h_addr(h_addr), .h_wdata(h_wdata),
    .bus_out(bus_out), .bus_oe(bus_oe), .strb_n(strb_n), .wen_n(wen_n)
  );

  mmx_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .rd_end(rd_end), .wr_end(wr_end),
    .bus_in(bus_in), .rdata(rdata), .done(done)
  );

  assign rd_phase = (st == MX_RDAT);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (strb_n && wen_n && !bus_oe));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(strb_n) && $past(bus_oe)) |-> (bus_oe && $stable(bus_out)));

  p_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_phase) |-> $past(!bus_oe && strb_n && wen_n));

  p_wen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen_n) |-> (bus_oe && $stable(bus_out) && strb_n));

  p_no_dual_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!strb_n && !wen_n));

  p_rd_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |-> !bus_oe);

  p_accept_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(req_ready)) |-> $past(req_valid));

  p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

endmodule

// File: tb/sim_xmem_mux_master.sv
module sim_xmem_mux_master;
  localparam int P = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, done, bus_oe, strb_n, wen_n;
  logic [7:0]  rdata, bus_out, bus_in;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  xmem_mux_master #(.PHASE_CYC(P), .ADDR_W(24), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .bus_out(bus_out), .bus_oe(bus_oe),
    .bus_in(bus_in), .strb_n(strb_n), .wen_n(wen_n)
  );

  // Behavioural chained latches plus memory (low 10 bits of latched address).
  logic [7:0] lat_lo = '0;
  logic [7:0] lat_hi = '0;
  logic [7:0] ext_mem [0:1023];
  logic [7:0] shadow  [0:1023];
  wire  [15:0] lat_addr = {lat_hi, lat_lo};

  always @(posedge strb_n) begin
    lat_hi <= lat_lo;
    lat_lo <= (bus_oe === 1'b1) ? bus_out : 8'h00;
  end
  always @(posedge wen_n) if (bus_oe === 1'b1) ext_mem[lat_addr[9:0]] <= bus_out;
  assign bus_in = (strb_n === 1'b0 && bus_oe === 1'b0) ? ext_mem[lat_addr[9:0]] : 8'h00;

  function automatic logic [7:0] init_val(input int i);
    return 8'(i) ^ 8'h5A ^ 8'(i >> 2);
  endfunction

  // Expected {done, oe, byte, strb_n, wen_n} in cycle c of a transaction.
  function automatic logic [11:0] exp_pins(input bit wr, input int c,
                                           input logic [23:0] a, input logic [7:0] d);
    if (c < P)            return {1'b0, 1'b1, a[15:8], c == P - 1, 1'b1};
    else if (c < 2 * P)   return {1'b0, 1'b1, a[7:0], c == 2 * P - 1, 1'b1};
    else if (wr)          return {1'b0, 1'b1, d, 1'b1, c == 3 * P - 1};
    else if (c == 2 * P)  return {1'b0, 1'b0, 8'h00, 1'b1, 1'b1};
    else                  return {1'b0, 1'b0, 8'h00, 1'b0, 1'b1};
  endfunction

  function automatic logic [11:0] act_pins();
    return {done, bus_oe, bus_oe ? bus_out : 8'h00, strb_n, wen_n};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic txn(input bit wr, input logic [23:0] a, input logic [7:0] d,
                     input bit poke, input string rtag);
    int len;
    logic [7:0] exp_rd;
    len = wr ? 3 * P : 3 * P + 1;
    exp_rd = shadow[a[9:0]];
    @(negedge clk);
    chk(req_ready === 1'b1, "R8", "ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < len; c++) begin
      string tag;
      if (c < 2 * P) tag = "R2";
      else if (wr) tag = "R6";
      else if (c == 2 * P) tag = "R4";
      else tag = "R5";
      chk(act_pins() === exp_pins(wr, c, a, d), tag, "pins {done,oe,byte,strb,wen}",
          32'(act_pins()), 32'(exp_pins(wr, c, a, d)));
      chk(!(strb_n === 1'b0 && wen_n === 1'b0), "R7", "strobes both low",
          {30'd0, strb_n, wen_n}, 32'd3);
      if (poke && c == 1) begin
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = a ^ 24'h000155; req_wdata = 8'hEE;
      end
      if (poke && c == 2) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(done === 1'b1, "R9", "done pulse", 32'(done), 32'd1);
    chk(req_ready === 1'b1, "R9", "ready with done", 32'(req_ready), 32'd1);
    if (!wr) chk(rdata === exp_rd, rtag, "read data", 32'(rdata), 32'(exp_rd));
    else shadow[a[9:0]] = d;
    @(negedge clk);
    chk(done === 1'b0, "R9", "done dropped", 32'(done), 32'd0);
    if (poke)
      chk(req_ready === 1'b1 && strb_n === 1'b1 && bus_oe === 1'b0, "R8",
          "no transaction after busy request", {29'd0, req_ready, strb_n, bus_oe}, 32'd6);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R9 watchdog act=hung exp=complete");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      ext_mem[i] = init_val(i);
      shadow[i]  = init_val(i);
    end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(act_pins() === 12'b0_0_00000000_1_1 && req_ready === 1'b1, "R1", "reset pins",
        {19'd0, req_ready, act_pins()}, {19'd0, 1'b1, 12'b0_0_00000000_1_1});
    rst_n = 1'b1;
    @(negedge clk);
    chk(act_pins() === 12'b0_0_00000000_1_1 && req_ready === 1'b1, "R1", "idle pins",
        {19'd0, req_ready, act_pins()}, {19'd0, 1'b1, 12'b0_0_00000000_1_1});

    // Directed corners
    txn(1'b0, 24'h000000, 8'h00, 1'b0, "R5");
    txn(1'b0, 24'hFFFFFF, 8'h00, 1'b0, "R5");
    txn(1'b1, 24'h120345, 8'hC3, 1'b0, "R6");
    txn(1'b0, 24'hAB0345, 8'h00, 1'b0, "R3");   // top byte differs
    txn(1'b0, 24'h000345, 8'h00, 1'b0, "R3");
    txn(1'b0, 24'h0001F0, 8'h00, 1'b1, "R8");   // busy request ignored
    txn(1'b0, 24'h0001F0 ^ 24'h000155, 8'h00, 1'b0, "R8"); // memory untouched
    txn(1'b1, 24'h00A5A5, 8'hFF, 1'b0, "R6");
    txn(1'b0, 24'h77A5A5, 8'h00, 1'b0, "R3");

    // Random mix
    for (int k = 0; k < 40; k++) begin
      logic [23:0] a;
      logic [7:0]  d;
      bit wr;
      a  = 24'($urandom);
      d  = 8'($urandom);
      wr = 1'($urandom);
      txn(wr, a, d, 1'b0, "R5");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule